// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block sits between a simple register-style host port and an 8-bit NAND flash device. The host writes a command byte or an address byte and the controller produces one latch-strobed flash write cycle with the command-latch or address-latch line raised. A data write produces the same cycle with both latch lines low. A read of the data register produces one read-enable strobe, and the sampled byte comes back as the read response. Chip enable is driven directly from a control bit. The controller's enable bit gates every bus access.

Each bus cycle has three phases: setup (latch lines and data valid, strobe still high), strobe (write or read enable low) and hold (strobe high again, latch lines and data still driven). The length of each phase is taken from the configuration register and counted in clock cycles. The flash ready/busy pin passes through a two-flop synchronizer and is visible in the status register.

The host request side is valid/ready. A request is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` drops while a bus cycle is running, and this holds back writes and data reads. Status and configuration reads are still served during a write cycle, but not while a data read is waiting for its byte. Each accepted read gives exactly one `host_rsp_valid` pulse. The response path has no back-pressure, so the host must take the pulse when it occurs. Register reads respond one cycle after acceptance. A data read responds in the first idle cycle after its hold phase.

Top module: `nand_cycle_ctrl`

## Requirements
- R1: After reset: `fl_ce_n`=1, `fl_cle`=0, `fl_ale`=0, `fl_we_n`=1, `fl_re_n`=1, `fl_dq_oe`=0 and `host_ready`=1. The control register (offset 1) reads 2 and the configuration register (offset 0) reads 0.
- R2: Control bit 1 drives `fl_ce_n` directly: 1 deselects the device and 0 selects it.
- R3: Control bit 0 enables the controller. While it is 0, writes to command (offset 2), address (offset 3) and data (offset 4) produce no strobe and no bus drive. A data read in this state returns 0 with no read strobe.
- R4: A command write with the controller enabled produces one write cycle. `fl_cle`=1 and `fl_ale`=0 throughout, and `fl_dq_o` carries the written byte with `fl_dq_oe`=1.
- R5: An address write produces the same cycle with `fl_ale`=1 and `fl_cle`=0.
- R6: `fl_we_n` (or `fl_re_n` for a read) stays low for exactly width+1 cycles. The width count is configuration bits [10:8], so width 0 gives a one-cycle strobe.
- R7: The number of cycles between the start of a bus cycle and the strobe falling equals the setup count, configuration bits [14:12]. A setup count of 0 makes the strobe fall in the first cycle.
- R8: After the strobe rises, the latch lines and data stay driven for exactly the hold count, configuration bits [6:4]. A hold count of 0 releases them at the same edge the strobe rises.
- R9: A data write produces a write cycle with `fl_cle`=`fl_ale`=0 and the byte driven on `fl_dq_o`.
- R10: A data read produces a read strobe with the same setup/width/hold timing and `fl_dq_oe`=0. `fl_dq_i` is sampled at the end of the last strobe cycle, and that byte is returned on `host_rsp_data[7:0]` with `host_rsp_valid` in the first idle cycle after the hold phase.
- R11: Status register (offset 5) bit 0 is `fl_rb` after a two-flop synchronizer (1 = ready). A read accepted one edge after a change still returns the old value. Status bit 1 is 1 while a bus cycle is in progress.
- R12: While a bus cycle runs, `host_ready` is 0 for any write and for data reads. Status and configuration reads are still accepted during a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted when high together with valid |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_addr | input | 3 | Register offset (0 cfg, 1 ctl, 2 cmd, 3 addr, 4 data, 5 status) |
| host_wdata | input | 16 | Write data; bus bytes use bits [7:0] |
| host_rsp_valid | output | 1 | One-cycle read response pulse |
| host_rsp_data | output | 16 | Read response data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The bench measures the setup, strobe and hold lengths at the pins for zero and maximum counts. An off-by-one counter would show up as a strobe one cycle too long, or as latch lines that linger after the strobe when the hold count is zero. For reads, the flash byte is presented only in the final strobe cycle and its complement is presented earlier, so a controller that samples early returns the complemented value. Further checks look for strobes or bus drive leaking out while the enable bit is 0, and for a one-flop synchronizer showing a ready change one edge too soon. The bench also confirms that writes are stalled while status reads still report the busy bit mid-cycle.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;
  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_CTL  = 3'd1,
    REG_CMD  = 3'd2,
    REG_ADDR = 3'd3,
    REG_DATA = 3'd4,
    REG_STAT = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_cyc_pkg::*;
#(
  parameter int unsigned TW  = 3,
  parameter int unsigned DQW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  cyc_kind_e      kind_i,
  input  logic [DQW-1:0] byte_i,
  input  logic [TW-1:0]  setup_i,
  input  logic [TW-1:0]  width_i,
  input  logic [TW-1:0]  hold_i,
  input  logic [DQW-1:0] dq_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DQW-1:0] rd_byte_o,
  output logic           cle_o,
  output logic           ale_o,
  output logic           we_n_o,
  output logic           re_n_o,
  output logic [DQW-1:0] dq_o,
  output logic           dq_oe_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  phase_e         ph_q;
  cyc_kind_e      kind_q;
  logic [TW-1:0]  cnt_q, setup_q, width_q, hold_q;
  logic [DQW-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      kind_q    <= CYC_CMD;
      cnt_q     <= '0;
      setup_q   <= '0;
      width_q   <= '0;
      hold_q    <= '0;
      byte_q    <= '0;
      rd_byte_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          kind_q  <= kind_i;
          byte_q  <= byte_i;
          setup_q <= setup_i;
          width_q <= width_i;
          hold_q  <= hold_i;
          cnt_q   <= '0;
          ph_q    <= (setup_i != '0) ? PH_SETUP : PH_STROBE;
        end
        PH_SETUP: begin
          if (cnt_q == setup_q - ONE) begin
            cnt_q <= '0;
            ph_q  <= PH_STROBE;
          end else cnt_q <= cnt_q + ONE;
        end
        PH_STROBE: begin
          if (cnt_q == width_q) begin
            cnt_q <= '0;
            if (kind_q == CYC_RD) rd_byte_o <= dq_i;
            if (hold_q != '0) ph_q <= PH_HOLD;
            else begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
            end
          end else cnt_q <= cnt_q + ONE;
        end
        default: begin
          if (cnt_q == hold_q - ONE) begin
            cnt_q  <= '0;
            ph_q   <= PH_IDLE;
            done_o <= 1'b1;
          end else cnt_q <= cnt_q + ONE;
        end
      endcase
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign cle_o   = busy_o && (kind_q == CYC_CMD);
  assign ale_o   = busy_o && (kind_q == CYC_ADDR);
  assign we_n_o  = !((ph_q == PH_STROBE) && (kind_q != CYC_RD));
  assign re_n_o  = !((ph_q == PH_STROBE) && (kind_q == CYC_RD));
  assign dq_oe_o = busy_o && (kind_q != CYC_RD);
  assign dq_o    = byte_q;

  // R10: a read strobe and a write strobe never overlap
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));
  // R4, R5: command and address latch are never raised together
  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));
  // R12: the host side only starts a cycle when the sequencer is idle
  assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R4: bus and latch lines hold still for the whole write strobe
  assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(dq_o) && $stable(cle_o) && $stable(ale_o)));
endmodule

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
  import nand_cyc_pkg::*;
#(
  parameter int unsigned HDW         = 16,
  parameter int unsigned DQW         = 8,
  parameter int unsigned TW          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_valid,
  output logic           host_ready,
  input  logic           host_we,
  input  logic [2:0]     host_addr,
  input  logic [HDW-1:0] host_wdata,
  output logic           host_rsp_valid,
  output logic [HDW-1:0] host_rsp_data,
  output logic           fl_ce_n,
  output logic           fl_cle,
  output logic           fl_ale,
  output logic           fl_we_n,
  output logic           fl_re_n,
  output logic [DQW-1:0] fl_dq_o,
  output logic           fl_dq_oe,
  input  logic [DQW-1:0] fl_dq_i,
  input  logic           fl_rb
);
  localparam int unsigned HOLD_LSB  = 4;
  localparam int unsigned WIDTH_LSB = 8;
  localparam int unsigned SETUP_LSB = 12;
  localparam int unsigned LW        = TW + 2;

  logic [HDW-1:0] cfg_q;
  logic [1:0]     ctl_q;
  logic           ctl_en;
  logic           rb_s;
  logic           seq_busy, seq_done, seq_start;
  logic [DQW-1:0] seq_rd_byte;
  logic           rd_pend_q;
  logic           reg_rsp_q;
  logic [HDW-1:0] reg_rdata_q, reg_rdata;
  logic           acc, bus_reg, is_data;
  cyc_kind_e      kind;
  logic [TW-1:0]  cfg_setup, cfg_width, cfg_hold;

  assign cfg_setup = cfg_q[SETUP_LSB +: TW];
  assign cfg_width = cfg_q[WIDTH_LSB +: TW];
  assign cfg_hold  = cfg_q[HOLD_LSB  +: TW];
  assign ctl_en    = ctl_q[0];
  assign fl_ce_n   = ctl_q[1];

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .async_i(fl_rb), .sync_o(rb_s)
  );

  assign is_data    = (host_addr == REG_DATA);
  assign bus_reg    = (host_addr == REG_CMD) || (host_addr == REG_ADDR) || is_data;
  assign host_ready = !seq_busy || (!host_we && !is_data && !rd_pend_q);
  assign acc        = host_valid && host_ready;
  assign seq_start  = acc && ctl_en && (host_we ? bus_reg : is_data);

  always_comb begin
    case (host_addr)
      REG_CMD:  kind = CYC_CMD;
      REG_ADDR: kind = CYC_ADDR;
      default:  kind = host_we ? CYC_WR : CYC_RD;
    endcase
  end

  always_comb begin
    case (host_addr)
      REG_CFG:  reg_rdata = cfg_q;
      REG_CTL:  reg_rdata = HDW'(ctl_q);
      REG_STAT: reg_rdata = HDW'({seq_busy, rb_s});
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      ctl_q       <= 2'b10;
      reg_rsp_q   <= 1'b0;
      reg_rdata_q <= '0;
      rd_pend_q   <= 1'b0;
    end else begin
      reg_rsp_q <= acc && !host_we && !seq_start;
      if (acc && !host_we) reg_rdata_q <= reg_rdata;
      if (acc && host_we && host_addr == REG_CFG) cfg_q <= host_wdata;
      if (acc && host_we && host_addr == REG_CTL) ctl_q <= host_wdata[1:0];
      if (seq_done) rd_pend_q <= 1'b0;
      if (seq_start && !host_we) rd_pend_q <= 1'b1;
    end
  end

  nand_cycle_seq #(.TW(TW), .DQW(DQW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(seq_start), .kind_i(kind), .byte_i(host_wdata[DQW-1:0]),
    .setup_i(cfg_setup), .width_i(cfg_width), .hold_i(cfg_hold),
    .dq_i(fl_dq_i),
    .busy_o(seq_busy), .done_o(seq_done), .rd_byte_o(seq_rd_byte),
    .cle_o(fl_cle), .ale_o(fl_ale), .we_n_o(fl_we_n), .re_n_o(fl_re_n),
    .dq_o(fl_dq_o), .dq_oe_o(fl_dq_oe)
  );

  assign host_rsp_valid = reg_rsp_q || (seq_done && rd_pend_q);
  assign host_rsp_data  = (seq_done && rd_pend_q) ? HDW'(seq_rd_byte) : reg_rdata_q;

  // checker state: strobe run length and pre-strobe cycle count
  logic          strobe_act;
  logic [LW-1:0] slen_q, plen_q;
  assign strobe_act = !fl_we_n || !fl_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slen_q <= '0;
      plen_q <= '0;
    end else begin
      slen_q <= strobe_act ? slen_q + LW'(1) : '0;
      if (seq_start) plen_q <= '0;
      else if (seq_busy && !strobe_act) plen_q <= plen_q + LW'(1);
    end
  end

  // R6: strobe length is width + 1 cycles
  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_act && $past(strobe_act)) |-> (slen_q == LW'(cfg_width) + LW'(1)));
  // R7: strobe falls after exactly the setup count
  assert_setup_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_act) |-> (plen_q == LW'(cfg_setup)));
  // R3: bus-register writes while disabled never start a cycle
  assert_disabled_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && bus_reg && !ctl_en && !seq_busy) |=> !seq_busy);
  // R12: writes are held back while a cycle runs
  assert_write_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && host_valid && host_we) |-> !host_ready);
endmodule

// File: tb/nand_cycle_ctrl_tb_top.sv
module nand_cycle_ctrl_tb_top;
  localparam int CLK_NS = 20;
  localparam int NV = 8;
  // {kind[1:0], byte[7:0], setup[2:0], width[2:0], hold[2:0]}; kind 0 cmd,1 addr,2 wr,3 rd
  localparam logic [18:0] VECS [0:NV-1] = '{
    {2'd0, 8'h90, 3'd0, 3'd1, 3'd0},
    {2'd1, 8'h3C, 3'd2, 3'd0, 3'd1},
    {2'd2, 8'hA5, 3'd1, 3'd3, 3'd2},
    {2'd3, 8'h5A, 3'd0, 3'd0, 3'd0},
    {2'd3, 8'hC3, 3'd3, 3'd2, 3'd4},
    {2'd0, 8'hFF, 3'd7, 3'd7, 3'd7},
    {2'd1, 8'h01, 3'd0, 3'd0, 3'd0},
    {2'd2, 8'h7E, 3'd0, 3'd0, 3'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, host_rsp_valid;
  logic [15:0] host_rsp_data;
  logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0]  fl_dq_o;
  logic [7:0]  fl_dq_i = '0;
  logic        fl_rb = 1'b1;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  nand_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_data(host_rsp_data),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rb(fl_rb)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic we, input logic [2:0] a, input logic [15:0] d);
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1;
    for (int i = 0; i < 200 && !host_ready; i++) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [15:0] d, output logic v);
    issue(1'b0, a, 16'h0);
    v = host_rsp_valid;
    d = host_rsp_data;
  endtask

  function automatic logic [15:0] cfg_word(input int s, input int w, input int h);
    return 16'((s << 12) | (w << 8) | (h << 4));
  endfunction

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ce_n", fl_ce_n, 1);
    check("R1 cle/ale", {fl_cle, fl_ale}, 0);
    check("R1 we_n/re_n", {fl_we_n, fl_re_n}, 3);
    check("R1 dq_oe", fl_dq_oe, 0);
    check("R1 ready", host_ready, 1);
    read_reg(3'd1, rd, v);
    check("R1 ctl readback", {v, rd}, 17'h10002);
    read_reg(3'd0, rd, v);
    check("R1 cfg readback", {v, rd}, 17'h10000);

    // R3 disabled: select chip but keep controller off
    issue(1'b1, 3'd1, 16'h0000);
    check("R2 ce selected", fl_ce_n, 0);
    issue(1'b1, 3'd2, 16'h0070);
    begin
      int act = 0;
      for (int i = 0; i < 6; i++) begin
        if (!fl_we_n || fl_cle || fl_dq_oe) act++;
        @(negedge clk);
      end
      check("R3 cmd ignored while disabled", act, 0);
    end
    read_reg(3'd4, rd, v);
    check("R3 data read while disabled", {v, rd}, 17'h10000);
    check("R3 no read strobe", fl_re_n, 1);
    issue(1'b1, 3'd1, 16'h0003);
    check("R2 ce deselected", fl_ce_n, 1);
    issue(1'b1, 3'd1, 16'h0001);
    check("R2 ce reselected", fl_ce_n, 0);

    // vector table
    for (int n = 0; n < NV; n++) begin
      logic [1:0] k; logic [7:0] b; int s, w, h;
      int setup, strb, hold; bit ph, fin;
      logic [3:0] snap; logic [7:0] dsnap; logic [15:0] rdat;
      {k, b} = VECS[n][18:9];
      s = int'(VECS[n][8:6]); w = int'(VECS[n][5:3]); h = int'(VECS[n][2:0]);
      issue(1'b1, 3'd0, cfg_word(s, w, h));
      issue(k == 2'd3 ? 1'b0 : 1'b1,
            k == 2'd0 ? 3'd2 : (k == 2'd1 ? 3'd3 : 3'd4), {8'h00, b});
      setup = 0; strb = 0; hold = 0; ph = 0; fin = 0;
      snap = '0; dsnap = '0; rdat = '0;
      for (int i = 0; i < 60 && !fin; i++) begin
        if (i > 0) @(negedge clk);
        if (k == 2'd3 ? host_rsp_valid : !fl_dq_oe) begin
          fin = 1;
          rdat = host_rsp_data;
        end else if (k == 2'd3 ? !fl_re_n : !fl_we_n) begin
          ph = 1; strb++;
          if (strb == 1) begin
            snap = {fl_cle, fl_ale, fl_dq_oe, fl_ce_n};
            dsnap = fl_dq_o;
          end
          fl_dq_i = (strb == w + 1) ? b : ~b;
        end else if (!ph) setup++;
        else hold++;
      end
      check($sformatf("R7 setup vec%0d", n), setup, s);
      check($sformatf("R6 strobe vec%0d", n), strb, w + 1);
      check($sformatf("R8 hold vec%0d", n), hold, h);
      case (k)
        2'd0: begin
          check($sformatf("R4 cle/ale/oe/ce vec%0d", n), snap, 4'b1010);
          check($sformatf("R4 byte vec%0d", n), dsnap, b);
        end
        2'd1: begin
          check($sformatf("R5 cle/ale/oe/ce vec%0d", n), snap, 4'b0110);
          check($sformatf("R5 byte vec%0d", n), dsnap, b);
        end
        2'd2: begin
          check($sformatf("R9 cle/ale/oe/ce vec%0d", n), snap, 4'b0010);
          check($sformatf("R9 byte vec%0d", n), dsnap, b);
        end
        default: begin
          check($sformatf("R10 cle/ale/oe/ce vec%0d", n), snap, 4'b0000);
          check($sformatf("R10 read data vec%0d", n), {fin, rdat}, {1'b1, 8'h00, b});
        end
      endcase
    end

    // R12 stall and busy flag during a long cycle
    issue(1'b1, 3'd0, cfg_word(0, 7, 7));
    issue(1'b1, 3'd2, 16'h00EE);
    host_valid = 1'b1; host_we = 1'b1; host_addr = 3'd3; host_wdata = 16'h0011;
    #1;
    check("R12 write stalled while busy", host_ready, 0);
    host_we = 1'b0; host_addr = 3'd4;
    #1;
    check("R12 data read stalled while busy", host_ready, 0);
    host_valid = 1'b0;
    @(negedge clk);
    read_reg(3'd5, rd, v);
    check("R11 busy bit mid-cycle", {v, rd[1]}, 2'b11);
    for (int i = 0; i < 40 && fl_dq_oe; i++) @(negedge clk);
    check("R12 idle after cycle", host_ready, 1);

    // R11 two-flop synchronizer latency
    fl_rb = 1'b0;
    repeat (4) @(negedge clk);
    read_reg(3'd5, rd, v);
    check("R11 busy pin seen", {v, rd[0]}, 2'b10);
    fl_rb = 1'b1;
    read_reg(3'd5, rd, v);
    read_reg(3'd5, rd, v);
    check("R11 ready not yet visible after one edge", {v, rd[1:0]}, 3'b100);
    read_reg(3'd5, rd, v);
    check("R11 ready visible after two flops", {v, rd[1:0]}, 3'b101);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule